// File: doc/BRIEF.md
# Exception Entry and Vector Generator

This block turns a one-cycle exception request into everything a processor pipeline needs to enter its handler. The request carries a class code. From that code and a snapshot of the processor's state (current PC, delay-slot flag, TLB-refill flag, coprocessor number, the EXL, BEV and interrupt-vector bits, the debug-mode flag and the exception base register), it produces the handler address. It also produces one-cycle write strobes with values for the exception return address, error return address, debug return address, cause code, branch-delay bit, coprocessor-error field, status flags and debug type bits.

There are three entry paths. The general path serves ordinary exceptions. Its vector is a base plus an offset, and the base and offset depend on BEV, IV, EXL and the refill flag. The error-level path serves NMI and soft reset and jumps to a fixed reset vector. The debug path serves the six debug causes and jumps to a fixed debug vector. Every accepted request forces kernel mode and clears the pipeline's delay-slot flag. All outputs are registered, so results appear one clock after the request.

Top module: `exc_entry`

## Requirements
- R1: While `rst` is high, every strobe output (`ack_o`, `err_o`, all `*_we_o`, all `*_set_o`, `kern_o`, `ds_clr_o`, `dbg_type_o`) is 0 and `next_pc_o` is 0.
- R2: A request whose class is a general exception code is acknowledged one clock later, at the same edge that raises `kern_o` and `ds_clr_o` and writes the code. The valid general codes are 0 to 13, 15, 23, 24 and 25. `code_we_o`=1 and `code_o` equals the class. At most one of the three return-address strobes is ever high.
- R3: The general vector is base plus 0x180. The base is 0xBFC00200 when BEV=1. Otherwise it is `ebase_i` with bits 9:0 cleared.
- R4: Interrupt (code 0) with IV=1 uses offset 0x200. TLB load (2) or TLB store (3) with `refill_i`=1 and EXL=0 uses offset 0x000. A refill with EXL=1, and `refill_i` on any other code, keeps 0x180.
- R5: On the general path with EXL=0, `epc_we_o`=1 with `epc_o` = PC-4 if `in_ds_i` else PC, `bd_we_o`=1 with `bd_o`=`in_ds_i`, and `exl_set_o`=1. With EXL=1 none of these three strobes fires, but the code and vector are still produced.
- R6: Coprocessor unusable (code 11) sets `ce_we_o` with `ce_o`=`cop_i`. No other class sets `ce_we_o`.
- R7: Class 32 (NMI) and class 33 (soft reset) write `errepc_o` using the delay-slot rule of R5 and set `erl_set_o` and `bev_set_o`. They also set `nmi_set_o` (class 32) or `srst_set_o` (class 33) and jump to 0xBFC00000. They write no cause code and no `epc_o`.
- R8: Classes 34 to 39 are debug entries. They set `dbg_type_o` bit (class-34), where bit 0 is single-step, 1 debug interrupt, 2 instruction break, 3 breakpoint instruction, 4 data store break and 5 data load break. They also set `dbg_mode_set_o`, write `depc_o` by the delay-slot rule (single-step always saves the plain PC) and jump to 0xBFC00480.
- R9: On error and debug entry, `bd_we_o`=1 with `bd_o`=0 when EXL=0, and `bd_we_o`=0 when EXL=1.
- R10: Class 0 (interrupt) while `dbg_mode_i`=1 is handled as class 35 (debug interrupt).
- R11: Any other class (14, 16 to 22, 26 to 31, 40 to 63) raises `err_o` for one cycle. It gives no `ack_o` and no write strobe, and `next_pc_o` and the return-address values keep their previous values.
- R12: In a cycle after no request, `ack_o`, `err_o` and all strobes are 0, and `next_pc_o` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | One-cycle exception request |
| cls_i | input | 6 | Exception class code |
| pc_i | input | XLEN | PC of the faulting instruction |
| in_ds_i | input | 1 | Fault came from a delay slot |
| refill_i | input | 1 | TLB miss needs refill (no matching entry) |
| cop_i | input | 2 | Coprocessor number for code 11 |
| exl_i | input | 1 | Current exception-level bit |
| bev_i | input | 1 | Current boot-vector bit |
| iv_i | input | 1 | Interrupt-vector select bit |
| dbg_mode_i | input | 1 | Processor is in debug mode |
| ebase_i | input | XLEN | Exception base register |
| ack_o | output | 1 | Request accepted |
| err_o | output | 1 | Unknown class code |
| next_pc_o | output | XLEN | Handler address |
| epc_we_o | output | 1 | Write exception return address |
| epc_o | output | XLEN | Exception return address |
| errepc_we_o | output | 1 | Write error return address |
| errepc_o | output | XLEN | Error return address |
| depc_we_o | output | 1 | Write debug return address |
| depc_o | output | XLEN | Debug return address |
| bd_we_o | output | 1 | Write branch-delay bit |
| bd_o | output | 1 | Branch-delay bit value |
| code_we_o | output | 1 | Write cause code |
| code_o | output | 5 | Cause code value |
| ce_we_o | output | 1 | Write coprocessor-error field |
| ce_o | output | 2 | Coprocessor-error value |
| exl_set_o | output | 1 | Set EXL |
| erl_set_o | output | 1 | Set ERL |
| bev_set_o | output | 1 | Set BEV |
| nmi_set_o | output | 1 | Set NMI status flag |
| srst_set_o | output | 1 | Set soft-reset status flag |
| dbg_type_o | output | 6 | Debug type bits to set |
| dbg_mode_set_o | output | 1 | Enter debug mode |
| kern_o | output | 1 | Force kernel mode |
| ds_clr_o | output | 1 | Clear delay-slot flag |

## Verification
The bench builds the block with its default parameters: a 32-bit address width, 4-byte instructions, a 10-bit base alignment and the three fixed vectors. The exception base is 0x80001234, so the masking of its low ten bits is visible in every non-BEV vector. With these values each of the three offsets, both bases and all three fixed vectors give distinct handler addresses. The delay-slot adjustment also shows up as a distinct 4-byte step in every return register.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int CLS_W     = 6;
  localparam int CODE_W    = 5;
  localparam int GEN_LIMIT = 32;
  localparam int CLS_NMI   = 32;
  localparam int CLS_SRST  = 33;
  localparam int DBG_BASE  = 34;
  localparam int NDBG      = 6;
  localparam int DBG_INT_IDX = 1;

  localparam int CODE_INT  = 0;
  localparam int CODE_TLBL = 2;
  localparam int CODE_TLBS = 3;
  localparam int CODE_CPU  = 11;

  typedef enum logic [1:0] {
    PATH_NONE = 2'd0,
    PATH_GEN  = 2'd1,
    PATH_ERR  = 2'd2,
    PATH_DBG  = 2'd3
  } path_e;

  function automatic logic gen_code_ok(input logic [CODE_W-1:0] c);
    logic ok;
    case (c)
      5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7,
      5'd8, 5'd9, 5'd10, 5'd11, 5'd12, 5'd13, 5'd15,
      5'd23, 5'd24, 5'd25: ok = 1'b1;
      default:             ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/exc_class_decode.sv
module exc_class_decode
  import exc_entry_pkg::*;
(
  input  logic [CLS_W-1:0]  cls_i,
  input  logic              dbg_mode_i,
  output path_e             path_o,
  output logic [CODE_W-1:0] code_o,
  output logic              is_int_o,
  output logic              is_tlb_o,
  output logic              is_cpu_o,
  output logic              is_nmi_o,
  output logic              is_dss_o,
  output logic [NDBG-1:0]   dbg_oh_o
);

  logic [CLS_W-1:0] eff;

  // interrupt raised in debug mode becomes a debug interrupt
  always_comb begin
    if (cls_i == CLS_W'(CODE_INT) && dbg_mode_i)
      eff = CLS_W'(DBG_BASE + DBG_INT_IDX);
    else
      eff = cls_i;
  end

  always_comb begin
    if (eff < CLS_W'(GEN_LIMIT))
      path_o = gen_code_ok(eff[CODE_W-1:0]) ? PATH_GEN : PATH_NONE;
    else if (eff == CLS_W'(CLS_NMI) || eff == CLS_W'(CLS_SRST))
      path_o = PATH_ERR;
    else if (eff >= CLS_W'(DBG_BASE) && eff < CLS_W'(DBG_BASE + NDBG))
      path_o = PATH_DBG;
    else
      path_o = PATH_NONE;
  end

  assign code_o   = eff[CODE_W-1:0];
  assign is_int_o = (path_o == PATH_GEN) && (code_o == CODE_W'(CODE_INT));
  assign is_tlb_o = (path_o == PATH_GEN) &&
                    (code_o == CODE_W'(CODE_TLBL) || code_o == CODE_W'(CODE_TLBS));
  assign is_cpu_o = (path_o == PATH_GEN) && (code_o == CODE_W'(CODE_CPU));
  assign is_nmi_o = (eff == CLS_W'(CLS_NMI));

  for (genvar g = 0; g < NDBG; g++) begin : g_dbg
    assign dbg_oh_o[g] = (path_o == PATH_DBG) && (eff == CLS_W'(DBG_BASE + g));
  end

  assign is_dss_o = dbg_oh_o[0];

endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
  import exc_entry_pkg::*;
#(
  parameter int             XLEN       = 32,
  parameter int             BASE_ALIGN = 10,
  parameter logic [XLEN-1:0] BEV_BASE  = 32'hBFC0_0200,
  parameter logic [XLEN-1:0] ERR_VEC   = 32'hBFC0_0000,
  parameter logic [XLEN-1:0] DBG_VEC   = 32'hBFC0_0480,
  parameter logic [XLEN-1:0] OFF_GEN   = 32'h0000_0180,
  parameter logic [XLEN-1:0] OFF_IRQ   = 32'h0000_0200,
  parameter logic [XLEN-1:0] OFF_REFILL = 32'h0000_0000
) (
  input  path_e            path_i,
  input  logic             is_int_i,
  input  logic             is_tlb_i,
  input  logic             iv_i,
  input  logic             refill_i,
  input  logic             exl_i,
  input  logic             bev_i,
  input  logic [XLEN-1:0]  ebase_i,
  output logic [XLEN-1:0]  vec_o
);

  localparam logic [XLEN-1:0] LOW_MASK =
    {{(XLEN-BASE_ALIGN){1'b0}}, {BASE_ALIGN{1'b1}}};

  logic [XLEN-1:0] base;
  logic [XLEN-1:0] off;

  assign base = bev_i ? BEV_BASE : (ebase_i & ~LOW_MASK);

  always_comb begin
    if (is_int_i && iv_i)
      off = OFF_IRQ;
    else if (is_tlb_i && refill_i && !exl_i)
      off = OFF_REFILL;
    else
      off = OFF_GEN;
  end

  always_comb begin
    case (path_i)
      PATH_GEN: vec_o = base + off;
      PATH_ERR: vec_o = ERR_VEC;
      PATH_DBG: vec_o = DBG_VEC;
      default:  vec_o = '0;
    endcase
  end

endmodule

// File: rtl/exc_ret_capture.sv
module exc_ret_capture #(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic            in_ds_i,
  input  logic            plain_i,
  output logic [XLEN-1:0] ret_o
);

  // a fault in a delay slot returns to the branch before it
  assign ret_o = (in_ds_i && !plain_i) ? (pc_i - XLEN'(INSN_BYTES)) : pc_i;

endmodule

// File: rtl/exc_entry.sv
module exc_entry
  import exc_entry_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter int              INSN_BYTES = 4,
  parameter int              BASE_ALIGN = 10,
  parameter logic [XLEN-1:0] BEV_BASE   = 32'hBFC0_0200,
  parameter logic [XLEN-1:0] ERR_VEC    = 32'hBFC0_0000,
  parameter logic [XLEN-1:0] DBG_VEC    = 32'hBFC0_0480,
  parameter logic [XLEN-1:0] OFF_GEN    = 32'h0000_0180,
  parameter logic [XLEN-1:0] OFF_IRQ    = 32'h0000_0200,
  parameter logic [XLEN-1:0] OFF_REFILL = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic [5:0]        cls_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              in_ds_i,
  input  logic              refill_i,
  input  logic [1:0]        cop_i,
  input  logic              exl_i,
  input  logic              bev_i,
  input  logic              iv_i,
  input  logic              dbg_mode_i,
  input  logic [XLEN-1:0]   ebase_i,
  output logic              ack_o,
  output logic              err_o,
  output logic [XLEN-1:0]   next_pc_o,
  output logic              epc_we_o,
  output logic [XLEN-1:0]   epc_o,
  output logic              errepc_we_o,
  output logic [XLEN-1:0]   errepc_o,
  output logic              depc_we_o,
  output logic [XLEN-1:0]   depc_o,
  output logic              bd_we_o,
  output logic              bd_o,
  output logic              code_we_o,
  output logic [4:0]        code_o,
  output logic              ce_we_o,
  output logic [1:0]        ce_o,
  output logic              exl_set_o,
  output logic              erl_set_o,
  output logic              bev_set_o,
  output logic              nmi_set_o,
  output logic              srst_set_o,
  output logic [5:0]        dbg_type_o,
  output logic              dbg_mode_set_o,
  output logic              kern_o,
  output logic              ds_clr_o
);

  path_e             path;
  logic [CODE_W-1:0] code;
  logic              is_int, is_tlb, is_cpu, is_nmi, is_dss;
  logic [NDBG-1:0]   dbg_oh;
  logic [XLEN-1:0]   vec;
  logic [XLEN-1:0]   ret;

  exc_class_decode u_dec (
    .cls_i      (cls_i),
    .dbg_mode_i (dbg_mode_i),
    .path_o     (path),
    .code_o     (code),
    .is_int_o   (is_int),
    .is_tlb_o   (is_tlb),
    .is_cpu_o   (is_cpu),
    .is_nmi_o   (is_nmi),
    .is_dss_o   (is_dss),
    .dbg_oh_o   (dbg_oh)
  );

  exc_vector_sel #(
    .XLEN       (XLEN),
    .BASE_ALIGN (BASE_ALIGN),
    .BEV_BASE   (BEV_BASE),
    .ERR_VEC    (ERR_VEC),
    .DBG_VEC    (DBG_VEC),
    .OFF_GEN    (OFF_GEN),
    .OFF_IRQ    (OFF_IRQ),
    .OFF_REFILL (OFF_REFILL)
  ) u_vec (
    .path_i   (path),
    .is_int_i (is_int),
    .is_tlb_i (is_tlb),
    .iv_i     (iv_i),
    .refill_i (refill_i),
    .exl_i    (exl_i),
    .bev_i    (bev_i),
    .ebase_i  (ebase_i),
    .vec_o    (vec)
  );

  exc_ret_capture #(
    .XLEN       (XLEN),
    .INSN_BYTES (INSN_BYTES)
  ) u_ret (
    .pc_i    (pc_i),
    .in_ds_i (in_ds_i),
    .plain_i (is_dss),
    .ret_o   (ret)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_o          <= 1'b0;
      err_o          <= 1'b0;
      next_pc_o      <= '0;
      epc_we_o       <= 1'b0;
      epc_o          <= '0;
      errepc_we_o    <= 1'b0;
      errepc_o       <= '0;
      depc_we_o      <= 1'b0;
      depc_o         <= '0;
      bd_we_o        <= 1'b0;
      bd_o           <= 1'b0;
      code_we_o      <= 1'b0;
      code_o         <= '0;
      ce_we_o        <= 1'b0;
      ce_o           <= '0;
      exl_set_o      <= 1'b0;
      erl_set_o      <= 1'b0;
      bev_set_o      <= 1'b0;
      nmi_set_o      <= 1'b0;
      srst_set_o     <= 1'b0;
      dbg_type_o     <= '0;
      dbg_mode_set_o <= 1'b0;
      kern_o         <= 1'b0;
      ds_clr_o       <= 1'b0;
    end else begin
      ack_o          <= 1'b0;
      err_o          <= 1'b0;
      epc_we_o       <= 1'b0;
      errepc_we_o    <= 1'b0;
      depc_we_o      <= 1'b0;
      bd_we_o        <= 1'b0;
      code_we_o      <= 1'b0;
      ce_we_o        <= 1'b0;
      exl_set_o      <= 1'b0;
      erl_set_o      <= 1'b0;
      bev_set_o      <= 1'b0;
      nmi_set_o      <= 1'b0;
      srst_set_o     <= 1'b0;
      dbg_type_o     <= '0;
      dbg_mode_set_o <= 1'b0;
      kern_o         <= 1'b0;
      ds_clr_o       <= 1'b0;
      if (req_i) begin
        if (path == PATH_NONE) begin
          err_o <= 1'b1;
        end else begin
          ack_o     <= 1'b1;
          kern_o    <= 1'b1;
          ds_clr_o  <= 1'b1;
          next_pc_o <= vec;
          case (path)
            PATH_GEN: begin
              code_we_o <= 1'b1;
              code_o    <= code;
              if (is_cpu) begin
                ce_we_o <= 1'b1;
                ce_o    <= cop_i;
              end
              if (!exl_i) begin
                epc_we_o  <= 1'b1;
                epc_o     <= ret;
                bd_we_o   <= 1'b1;
                bd_o      <= in_ds_i;
                exl_set_o <= 1'b1;
              end
            end
            PATH_ERR: begin
              errepc_we_o <= 1'b1;
              errepc_o    <= ret;
              erl_set_o   <= 1'b1;
              bev_set_o   <= 1'b1;
              nmi_set_o   <= is_nmi;
              srst_set_o  <= !is_nmi;
              if (!exl_i) begin
                bd_we_o <= 1'b1;
                bd_o    <= 1'b0;
              end
            end
            default: begin
              depc_we_o      <= 1'b1;
              depc_o         <= ret;
              dbg_type_o     <= dbg_oh;
              dbg_mode_set_o <= 1'b1;
              if (!exl_i) begin
                bd_we_o <= 1'b1;
                bd_o    <= 1'b0;
              end
            end
          endcase
        end
      end
    end
  end

  // R5: with EXL already set, a general exception leaves EPC and BD alone
  assert_exl_keeps_epc_R5: assert property (@(posedge clk) disable iff (rst)
    (req_i && exl_i && cls_i < 6'd32 && !(cls_i == 6'd0 && dbg_mode_i))
      |=> (!epc_we_o && !bd_we_o && !exl_set_o));

  assert_one_return_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({epc_we_o, errepc_we_o, depc_we_o}));

  assert_err_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (!ack_o && !code_we_o && !epc_we_o && !errepc_we_o &&
               !depc_we_o && !bd_we_o && $stable(next_pc_o)));

  assert_dbg_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dbg_type_o) && (dbg_mode_set_o == (dbg_type_o != 6'd0)));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !req_i |=> (!ack_o && !err_o && $stable(next_pc_o)));

  assert_entry_kernel_R2: assert property (@(posedge clk) disable iff (rst)
    (req_i && cls_i == 6'd8) |=> (ack_o && kern_o && ds_clr_o && code_we_o));

endmodule

// File: tb/tb_exc_entry.sv
`timescale 1ns/1ps
module tb_exc_entry;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic [5:0]  cls = '0;
  logic [31:0] pc = '0;
  logic        ds = 1'b0, rf = 1'b0, exl = 1'b0, bev = 1'b0, iv = 1'b0, dbgm = 1'b0;
  logic [1:0]  cop = '0;
  logic [31:0] ebase = 32'h8000_1234;

  logic        ack, err, epc_we, errepc_we, depc_we, bd_we, bd, code_we, ce_we;
  logic        exl_set, erl_set, bev_set, nmi_set, srst_set, dbg_mode_set, kern, ds_clr;
  logic [31:0] next_pc, epc, errepc, depc;
  logic [4:0]  code;
  logic [1:0]  ce;
  logic [5:0]  dbg_type;

  always #2.5 clk = ~clk;

  exc_entry dut (
    .clk(clk), .rst(rst), .req_i(req), .cls_i(cls), .pc_i(pc), .in_ds_i(ds),
    .refill_i(rf), .cop_i(cop), .exl_i(exl), .bev_i(bev), .iv_i(iv),
    .dbg_mode_i(dbgm), .ebase_i(ebase), .ack_o(ack), .err_o(err),
    .next_pc_o(next_pc), .epc_we_o(epc_we), .epc_o(epc),
    .errepc_we_o(errepc_we), .errepc_o(errepc), .depc_we_o(depc_we),
    .depc_o(depc), .bd_we_o(bd_we), .bd_o(bd), .code_we_o(code_we),
    .code_o(code), .ce_we_o(ce_we), .ce_o(ce), .exl_set_o(exl_set),
    .erl_set_o(erl_set), .bev_set_o(bev_set), .nmi_set_o(nmi_set),
    .srst_set_o(srst_set), .dbg_type_o(dbg_type),
    .dbg_mode_set_o(dbg_mode_set), .kern_o(kern), .ds_clr_o(ds_clr)
  );

  // fl = {ds, refill, exl, bev, iv, dbg_mode}
  // we = {epc, errepc, depc, code}; bdx = {bd_we, bd}
  // st = {exl_set, erl_set, bev_set, nmi_set, srst_set}
  typedef struct packed {
    logic [5:0]  cls;
    logic [31:0] pc;
    logic [5:0]  fl;
    logic [1:0]  cop;
    logic [31:0] e_pc;
    logic [31:0] e_ret;
    logic [3:0]  e_we;
    logic [1:0]  e_bd;
    logic [4:0]  e_code;
    logic [4:0]  e_st;
    logic [5:0]  e_dbg;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{6'd8,  32'h1000, 6'b000000, 2'd0, 32'h8000_1180, 32'h1000, 4'b1001, 2'b10, 5'd8,  5'b10000, 6'b000000},
    '{6'd8,  32'h2008, 6'b100000, 2'd0, 32'h8000_1180, 32'h2004, 4'b1001, 2'b11, 5'd8,  5'b10000, 6'b000000},
    '{6'd9,  32'h3000, 6'b000100, 2'd0, 32'hBFC0_0380, 32'h3000, 4'b1001, 2'b10, 5'd9,  5'b10000, 6'b000000},
    '{6'd0,  32'h4000, 6'b000010, 2'd0, 32'h8000_1200, 32'h4000, 4'b1001, 2'b10, 5'd0,  5'b10000, 6'b000000},
    '{6'd0,  32'h4100, 6'b000000, 2'd0, 32'h8000_1180, 32'h4100, 4'b1001, 2'b10, 5'd0,  5'b10000, 6'b000000},
    '{6'd2,  32'h4200, 6'b010000, 2'd0, 32'h8000_1000, 32'h4200, 4'b1001, 2'b10, 5'd2,  5'b10000, 6'b000000},
    '{6'd3,  32'h4300, 6'b010100, 2'd0, 32'hBFC0_0200, 32'h4300, 4'b1001, 2'b10, 5'd3,  5'b10000, 6'b000000},
    '{6'd2,  32'h4400, 6'b011000, 2'd0, 32'h8000_1180, 32'h0000, 4'b0001, 2'b00, 5'd2,  5'b00000, 6'b000000},
    '{6'd12, 32'h4500, 6'b101000, 2'd0, 32'h8000_1180, 32'h0000, 4'b0001, 2'b00, 5'd12, 5'b00000, 6'b000000},
    '{6'd11, 32'h4600, 6'b000000, 2'd2, 32'h8000_1180, 32'h4600, 4'b1001, 2'b10, 5'd11, 5'b10000, 6'b000000},
    '{6'd32, 32'h5004, 6'b100000, 2'd0, 32'hBFC0_0000, 32'h5000, 4'b0100, 2'b10, 5'd0,  5'b01110, 6'b000000},
    '{6'd33, 32'h6000, 6'b001000, 2'd0, 32'hBFC0_0000, 32'h6000, 4'b0100, 2'b00, 5'd0,  5'b01101, 6'b000000},
    '{6'd34, 32'h7008, 6'b100000, 2'd0, 32'hBFC0_0480, 32'h7008, 4'b0010, 2'b10, 5'd0,  5'b00000, 6'b000001},
    '{6'd36, 32'h7010, 6'b100000, 2'd0, 32'hBFC0_0480, 32'h700C, 4'b0010, 2'b10, 5'd0,  5'b00000, 6'b000100},
    '{6'd39, 32'h7100, 6'b001000, 2'd0, 32'hBFC0_0480, 32'h7100, 4'b0010, 2'b00, 5'd0,  5'b00000, 6'b100000},
    '{6'd0,  32'h7200, 6'b000001, 2'd0, 32'hBFC0_0480, 32'h7200, 4'b0010, 2'b10, 5'd0,  5'b00000, 6'b000010},
    '{6'd24, 32'h7300, 6'b000000, 2'd0, 32'h8000_1180, 32'h7300, 4'b1001, 2'b10, 5'd24, 5'b10000, 6'b000000},
    '{6'd13, 32'h7400, 6'b010000, 2'd0, 32'h8000_1180, 32'h7400, 4'b1001, 2'b10, 5'd13, 5'b10000, 6'b000000}
  };

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic pulse_quiet(input string tag);
    check({tag, " strobes"},
          {24'd0, ack, err, epc_we, errepc_we, depc_we, bd_we, code_we, ce_we}, 32'd0);
    check({tag, " flags"},
          {23'd0, exl_set, erl_set, bev_set, nmi_set, srst_set, dbg_mode_set, kern, ds_clr,
           (dbg_type != 6'd0)}, 32'd0);
  endtask

  task automatic fire(input logic [5:0] c, input logic [31:0] p, input logic [5:0] f,
                      input logic [1:0] cp);
    @(negedge clk);
    cls = c; pc = p; cop = cp;
    {ds, rf, exl, bev, iv, dbgm} = f;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    logic [31:0] held_pc, held_epc;
    repeat (3) @(negedge clk);
    // R1: reset state
    pulse_quiet("R1 reset");
    check("R1 reset next_pc", next_pc, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    pulse_quiet("R12 idle after reset");

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      fire(v.cls, v.pc, v.fl, v.cop);
      // R2 R3 R4 R7 R8 R10: vector and acceptance
      check($sformatf("R2 row%0d ack/kern/dsclr", i), {29'd0, ack, kern, ds_clr}, 32'd7);
      check($sformatf("R3 R4 row%0d next_pc", i), next_pc, v.e_pc);
      check($sformatf("R5 R7 R8 row%0d write strobes", i),
            {28'd0, epc_we, errepc_we, depc_we, code_we}, {28'd0, v.e_we});
      check($sformatf("R5 R9 row%0d bd", i), {30'd0, bd_we, bd_we & bd}, {30'd0, v.e_bd});
      check($sformatf("R5 R7 row%0d status sets", i),
            {27'd0, exl_set, erl_set, bev_set, nmi_set, srst_set}, {27'd0, v.e_st});
      check($sformatf("R8 R10 row%0d dbg type", i), {25'd0, dbg_mode_set, dbg_type},
            {25'd0, (v.e_dbg != 6'd0), v.e_dbg});
      check($sformatf("R6 row%0d ce strobe", i), {31'd0, ce_we}, {31'd0, (v.cls == 6'd11)});
      if (v.e_we[3]) check($sformatf("R5 row%0d epc", i), epc, v.e_ret);
      if (v.e_we[2]) check($sformatf("R7 row%0d errepc", i), errepc, v.e_ret);
      if (v.e_we[1]) check($sformatf("R8 row%0d depc", i), depc, v.e_ret);
      if (v.e_we[0]) check($sformatf("R2 row%0d code", i), {27'd0, code}, {27'd0, v.e_code});
      if (v.cls == 6'd11) check("R6 ce value", {30'd0, ce}, {30'd0, v.cop});
    end

    // R12: a cycle without request
    held_pc = next_pc;
    @(negedge clk);
    pulse_quiet("R12 idle");
    check("R12 next_pc holds", next_pc, held_pc);

    // a known entry to set a reference, then unknown codes
    fire(6'd4, 32'h9000, 6'b000000, 2'd0);
    check("R2 adel next_pc", next_pc, 32'h8000_1180);
    held_pc = next_pc;
    held_epc = epc;
    foreach (VECS[k]) if (k < 3) begin
      logic [5:0] bad;
      bad = (k == 0) ? 6'd14 : (k == 1) ? 6'd40 : 6'd27;
      fire(bad, 32'hA000, 6'b000000, 2'd1);
      check($sformatf("R11 code %0d err/ack", bad), {30'd0, err, ack}, 32'd2);
      check($sformatf("R11 code %0d writes", bad),
            {27'd0, epc_we, errepc_we, depc_we, bd_we, code_we}, 32'd0);
      check($sformatf("R11 code %0d next_pc", bad), next_pc, held_pc);
      check($sformatf("R11 code %0d epc", bad), epc, held_epc);
    end

    // R1: reset again clears pulses and pc
    fire(6'd8, 32'hB000, 6'b000000, 2'd0);
    @(negedge clk);
    rst = 1'b1;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    pulse_quiet("R1 reset with request");
    check("R1 reset next_pc again", next_pc, 32'd0);
    rst = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule